// File: doc/BRIEF.md
# Interrupt-capable GPIO bank controller

This block manages a bank of general-purpose pins (up to 32) behind a small 32-bit register port. Each pin is one of three kinds. A plain input is sampled into an input-data register. A plain output is driven from an output-data register with its output enable raised. An interrupt input is sensed and reported through a status register. Every pin signal coming in from the pads passes through a multi-flop synchronizer before anything looks at it.

Each interrupt input has its own sense settings. It can be level or edge sensitive, active high or active low, and an edge-sensed pin can respond to one edge or to both. Level status follows the pin and is not latched. Edge status is latched and is cleared by writing ones to a clear register. Interrupt enables are lowered through one register, where zero bits disable, and raised through another, where one bits enable. One combined request line is raised whenever any enabled pin has status.

Host software programs the sense settings first, then switches the pin to interrupt mode, clears any stale edge status and finally unmasks the pin. Its handler reads the status, clears the bits it serves and repeats until nothing enabled is pending.

Top module: `gpb_bank`

## Requirements
- R1: After reset every configuration register, the output data and the enables read 0, `pin_o`, `pin_oe_o` and `irq_o` are 0, and the input-data register reads 0 until the pins change.
- R2: A pin whose bit in the mode register (offset 0x00) is 0 has `pin_oe_o` equal to its bit in the direction register (offset 0x04, 1 = output). `pin_o` always equals the output-data register (offset 0x08), and that register reads back what was written.
- R3: Reading offset 0x0C returns the pin values after a two-flop synchronizer. A pin change made before clock edge 1 is captured by a read strobed at edge 3 but not by reads strobed at edges 1 and 2. Read data appears on `rdata_o` at the edge that samples `rd_en_i`.
- R4: A pin whose mode bit (offset 0x00) is 1 is an interrupt input, and its `pin_oe_o` is 0 whatever its direction bit is.
- R5: Level sensing is selected when the pin's bit in the sense register (offset 0x24) is 0. Its status bit (offset 0x10) then equals the synchronized pin XOR its polarity bit (offset 0x20, 1 = active low). The status follows the level and is not latched.
- R6: Edge sensing is selected when the sense bit is 1 and the both-edge bit (offset 0x4C) is 0. With polarity 0 a rising edge latches the status bit, and with polarity 1 a falling edge latches it. An edge made before clock edge 1 is latched at edge 3.
- R7: Edge sensing with the both-edge bit at 1 latches status on rising and falling edges alike, whatever the polarity. The both-edge register reads back its value.
- R8: Writing offset 0x14 clears the latched edge status of every pin whose data bit is 1. Zero bits leave status unchanged, and level-sensed status is not affected.
- R9: When an edge is detected in the same cycle as a clear write for that bit, the status bit stays set.
- R10: A write to offset 0x18 disables every pin whose data bit is 0 and leaves the others as they were. A write of 1 bits to offset 0x1C enables those pins. Reading 0x18 returns the enables (1 = enabled).
- R11: `irq_o` is 1 exactly while some pin has both status and enable set. It responds in the same cycle as a status or enable change.
- R12: Status bits of pins not in interrupt mode read 0. Bits at or above the pin count read 0. Offset 0x14, offset 0x1C and offsets not listed read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered on the strobed edge |
| pin_i | input | NPINS | Pad input values (asynchronous) |
| pin_o | output | NPINS | Pad output values |
| pin_oe_o | output | NPINS | Pad output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Register writes take effect at the clock edge that samples the strobe. `pin_o`, `pin_oe_o`, the enables and `irq_o` are compared at the falling edge right after it. A read strobed at one edge is compared at the next falling edge. Pin stimulus moves on a falling edge:
- level status and the request change after two rising edges;
- latched edge status changes after three rising edges.

The bench issues reads exactly on the edges before and at those deadlines, so an extra or missing register stage is reported. The same-cycle race between an edge and a clear is staged by placing the clear write on the third edge after the pin change.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

   localparam int unsigned DATA_W = 32;

   // Register byte offsets; software depends on this layout.
   localparam logic [7:0] OFF_MODE   = 8'h00;
   localparam logic [7:0] OFF_DIR    = 8'h04;
   localparam logic [7:0] OFF_OUT    = 8'h08;
   localparam logic [7:0] OFF_IN     = 8'h0C;
   localparam logic [7:0] OFF_STAT   = 8'h10;
   localparam logic [7:0] OFF_CLR    = 8'h14;
   localparam logic [7:0] OFF_MASK   = 8'h18;
   localparam logic [7:0] OFF_UNMASK = 8'h1C;
   localparam logic [7:0] OFF_POL    = 8'h20;
   localparam logic [7:0] OFF_SENSE  = 8'h24;
   localparam logic [7:0] OFF_BOTH   = 8'h4C;

   typedef struct packed {
      logic mode;
      logic dir;
      logic outd;
      logic clr;
      logic mask;
      logic unmask;
      logic pol;
      logic sense;
      logic both;
   } wr_dec_t;

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpb_sense.sv
module gpb_sense #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NPINS-1:0] sync_i,
   input  logic [NPINS-1:0] mode_i,
   input  logic [NPINS-1:0] pol_i,
   input  logic [NPINS-1:0] sense_i,
   input  logic [NPINS-1:0] both_i,
   input  logic [NPINS-1:0] clr_i,
   output logic [NPINS-1:0] status_o
);

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic prev_q;
      logic latch_q;
      logic rise, fall, hit, edge_mode;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) prev_q <= 1'b0;
         else         prev_q <= sync_i[i];
      end

      assign rise      = sync_i[i] & ~prev_q;
      assign fall      = ~sync_i[i] & prev_q;
      assign hit       = both_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);
      assign edge_mode = mode_i[i] & sense_i[i];

      // A new edge takes priority over a clear in the same cycle.
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)         latch_q <= 1'b0;
         else if (!edge_mode) latch_q <= 1'b0;
         else if (hit)        latch_q <= 1'b1;
         else if (clr_i[i])   latch_q <= 1'b0;
      end

      always_comb begin
         if (!mode_i[i])      status_o[i] = 1'b0;
         else if (sense_i[i]) status_o[i] = latch_q;
         else                 status_o[i] = sync_i[i] ^ pol_i[i];
      end
   end

endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
   import gpb_pkg::*;
#(
   parameter int unsigned NPINS         = 32,
   parameter int unsigned ADDR_W        = 8,
   parameter bit          HAS_BOTH_EDGE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [NPINS-1:0]  sync_i,
   input  logic [NPINS-1:0]  status_i,
   output logic [NPINS-1:0]  mode_o,
   output logic [NPINS-1:0]  dir_o,
   output logic [NPINS-1:0]  outd_o,
   output logic [NPINS-1:0]  pol_o,
   output logic [NPINS-1:0]  sense_o,
   output logic [NPINS-1:0]  both_o,
   output logic [NPINS-1:0]  en_o,
   output logic [NPINS-1:0]  clr_o
);

   logic [NPINS-1:0] wbits;
   wr_dec_t          wd;

   assign wbits = wdata_i[NPINS-1:0];

   always_comb begin
      wd        = '0;
      wd.mode   = wr_en_i && (addr_i == ADDR_W'(OFF_MODE));
      wd.dir    = wr_en_i && (addr_i == ADDR_W'(OFF_DIR));
      wd.outd   = wr_en_i && (addr_i == ADDR_W'(OFF_OUT));
      wd.clr    = wr_en_i && (addr_i == ADDR_W'(OFF_CLR));
      wd.mask   = wr_en_i && (addr_i == ADDR_W'(OFF_MASK));
      wd.unmask = wr_en_i && (addr_i == ADDR_W'(OFF_UNMASK));
      wd.pol    = wr_en_i && (addr_i == ADDR_W'(OFF_POL));
      wd.sense  = wr_en_i && (addr_i == ADDR_W'(OFF_SENSE));
      wd.both   = wr_en_i && (addr_i == ADDR_W'(OFF_BOTH));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_o  <= '0;
         dir_o   <= '0;
         outd_o  <= '0;
         pol_o   <= '0;
         sense_o <= '0;
      end else begin
         if (wd.mode)  mode_o  <= wbits;
         if (wd.dir)   dir_o   <= wbits;
         if (wd.outd)  outd_o  <= wbits;
         if (wd.pol)   pol_o   <= wbits;
         if (wd.sense) sense_o <= wbits;
      end
   end

   // Enables: zero bits of a mask write drop, one bits of an unmask write raise.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        en_o <= '0;
      else if (wd.mask)   en_o <= en_o & wbits;
      else if (wd.unmask) en_o <= en_o | wbits;
   end

   if (HAS_BOTH_EDGE) begin : g_both
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      both_o <= '0;
         else if (wd.both) both_o <= wbits;
      end
   end else begin : g_no_both
      assign both_o = '0;
   end

   assign clr_o = wd.clr ? wbits : '0;

   logic [NPINS-1:0]  sel_bits;
   logic              sel_hit;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      sel_hit  = 1'b1;
      sel_bits = '0;
      case (addr_i)
         ADDR_W'(OFF_MODE):  sel_bits = mode_o;
         ADDR_W'(OFF_DIR):   sel_bits = dir_o;
         ADDR_W'(OFF_OUT):   sel_bits = outd_o;
         ADDR_W'(OFF_IN):    sel_bits = sync_i;
         ADDR_W'(OFF_STAT):  sel_bits = status_i;
         ADDR_W'(OFF_MASK):  sel_bits = en_o;
         ADDR_W'(OFF_POL):   sel_bits = pol_o;
         ADDR_W'(OFF_SENSE): sel_bits = sense_o;
         ADDR_W'(OFF_BOTH):  sel_bits = both_o;
         default:            sel_hit  = 1'b0;
      endcase
      rd_mux = '0;
      if (sel_hit) rd_mux[NPINS-1:0] = sel_bits;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rdata_o <= '0;
      else if (rd_en_i) rdata_o <= rd_mux;
   end

endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
   import gpb_pkg::*;
#(
   parameter int unsigned NPINS         = 32,
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          HAS_BOTH_EDGE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   input  logic [NPINS-1:0]  pin_i,
   output logic [NPINS-1:0]  pin_o,
   output logic [NPINS-1:0]  pin_oe_o,
   output logic              irq_o
);

   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("gpb_bank: NPINS must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpb_bank: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpb_bank: ADDR_W too narrow for the register map");
   end

   logic [NPINS-1:0] sync_w, status_w;
   logic [NPINS-1:0] mode_q, dir_q, outd_q, pol_q, sense_q, both_q, en_q, clr_w;

   gpb_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_i),
      .q_o   (sync_w)
   );

   gpb_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .HAS_BOTH_EDGE(HAS_BOTH_EDGE)) u_regs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o),
      .sync_i  (sync_w),
      .status_i(status_w),
      .mode_o  (mode_q),
      .dir_o   (dir_q),
      .outd_o  (outd_q),
      .pol_o   (pol_q),
      .sense_o (sense_q),
      .both_o  (both_q),
      .en_o    (en_q),
      .clr_o   (clr_w)
   );

   gpb_sense #(.NPINS(NPINS)) u_sense (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sync_i  (sync_w),
      .mode_i  (mode_q),
      .pol_i   (pol_q),
      .sense_i (sense_q),
      .both_i  (both_q),
      .clr_i   (clr_w),
      .status_o(status_w)
   );

   assign pin_o    = outd_q;
   assign pin_oe_o = dir_q & ~mode_q;
   assign irq_o    = |(status_w & en_q);

endmodule

// File: rtl/gpb_bank_chk.sv
module gpb_bank_chk
   import gpb_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic [31:0]       wdata_i,
   input logic [NPINS-1:0]  pin_o,
   input logic [NPINS-1:0]  pin_oe_o,
   input logic              irq_o,
   input logic [NPINS-1:0]  mode_q,
   input logic [NPINS-1:0]  en_q,
   input logic [NPINS-1:0]  status_w
);

   // R4
   int_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_oe_o & mode_q) == '0);

   // R2
   out_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(OFF_OUT)) |=> (pin_o == $past(wdata_i[NPINS-1:0])));

   // R10
   mask_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(OFF_MASK)) |=> ((en_q & ~$past(wdata_i[NPINS-1:0])) == '0));

   // R10
   unmask_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(OFF_UNMASK)) |=>
      ((en_q & $past(wdata_i[NPINS-1:0])) == $past(wdata_i[NPINS-1:0])));

   // R11
   irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q == '0) |-> !irq_o);

   // R12
   stat_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_w & ~mode_q) == '0);

endmodule

bind gpb_bank gpb_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .wr_en_i (wr_en_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .pin_o   (pin_o),
   .pin_oe_o(pin_oe_o),
   .irq_o   (irq_o),
   .mode_q  (mode_q),
   .en_q    (en_q),
   .status_w(status_w)
);

// File: tb/test_gpb_bank.sv
module test_gpb_bank;

   localparam int unsigned N = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [N-1:0]  pins = '0;
   logic [N-1:0]  pin_o, pin_oe;
   logic          irq;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] exp;
      logic [7:0]  addr;
      string       tag;
   } item_t;
   item_t sb[$];
   logic  rd_seen = 1'b0;

   always #4 clk = ~clk;

   gpb_bank #(.NPINS(N)) i_gpb_bank (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .wr_en_i (wr_en),
      .rd_en_i (rd_en),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .pin_i   (pins),
      .pin_o   (pin_o),
      .pin_oe_o(pin_oe),
      .irq_o   (irq)
   );

   always @(posedge clk) rd_seen <= rd_en;

   // Monitor: compares each read against the scoreboard head.
   always @(negedge clk) begin
      if (rd_seen) begin
         checks++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL unexpected read data: got %h expected none", rdata);
         end else begin
            item_t it;
            it = sb.pop_front();
            if (rdata !== it.exp) begin
               fails++;
               $display("FAIL %s read @%h: got %h expected %h", it.tag, it.addr, rdata, it.exp);
            end
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
      item_t it;
      it.exp = e; it.addr = a; it.tag = tag;
      sb.push_back(it);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk(logic [31:0] got, logic [31:0] e, string tag);
      checks++;
      if (got !== e) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, e);
      end
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk(32'(pin_o), 0, "R1 pin_o");
      chk(32'(pin_oe), 0, "R1 pin_oe_o");
      chk(32'(irq), 0, "R1 irq_o");
      rd(8'h18, 0, "R1 enables");
      rd(8'h00, 0, "R1 mode");
      rd(8'h0C, 0, "R1 input");

      // R2 outputs and direction
      wr(8'h08, 32'h00A5A5A5);
      wr(8'h04, 32'h0000FF0F);
      chk(32'(pin_o), 32'h00A5A5A5, "R2 pin_o");
      chk(32'(pin_oe), 32'h0000FF0F, "R2 pin_oe_o");
      rd(8'h08, 32'h00A5A5A5, "R2 out readback");
      // R12 bits above the pin count
      wr(8'h08, 32'hFFFFFFFF);
      rd(8'h08, 32'h00FFFFFF, "R12 upper bits");
      // R4 interrupt mode forces input
      wr(8'h00, 32'h0000000F);
      chk(32'(pin_oe), 32'h0000FF00, "R4 pin_oe_o");

      // R3 synchronizer latency
      pins = 24'h123456;
      rd(8'h0C, 0, "R3 edge1");
      rd(8'h0C, 0, "R3 edge2");
      rd(8'h0C, 32'h00123456, "R3 edge3");

      wr(8'h04, 0); wr(8'h08, 0); wr(8'h00, 0);
      pins = '0; tick(3);

      // R5 level sensing
      wr(8'h20, 32'h2);
      wr(8'h00, 32'h3);
      rd(8'h10, 32'h2, "R5 low level active");
      pins = 24'h0F0003; tick(2);
      rd(8'h10, 32'h1, "R5 level follows / R12 non-interrupt pins");
      wr(8'h14, 32'h3);
      rd(8'h10, 32'h1, "R8 clear ignores level");

      // R10 / R11 enables and request
      chk(32'(irq), 0, "R11 masked");
      wr(8'h1C, 32'h1);
      chk(32'(irq), 1, "R11 unmasked");
      wr(8'h18, 32'hFFFFFFFE);
      chk(32'(irq), 0, "R11 remasked");
      rd(8'h18, 0, "R10 mask drop");
      wr(8'h1C, 32'h3);
      rd(8'h18, 32'h3, "R10 unmask");
      wr(8'h18, 32'hFFFFFFFD);
      rd(8'h18, 32'h1, "R10 ones keep");
      chk(32'(irq), 1, "R11 still pending");
      pins = 24'h0F0002; tick(1);
      chk(32'(irq), 1, "R11 before sync");
      tick(1);
      chk(32'(irq), 0, "R11 level gone");
      wr(8'h18, 0);
      wr(8'h1C, 32'hFFFFFFFF);
      rd(8'h18, 32'h00FFFFFF, "R10 R12 enable width");
      wr(8'h18, 0);

      // R6 single-edge sensing
      pins = '0; tick(3);
      wr(8'h24, 32'h3);
      rd(8'h10, 0, "R6 no stale edge");
      pins = 24'h3; tick(2);
      rd(8'h10, 0, "R6 not yet latched");
      rd(8'h10, 32'h1, "R6 rising latched");
      wr(8'h1C, 32'h3);
      chk(32'(irq), 1, "R11 edge request");
      pins = '0; tick(3);
      rd(8'h10, 32'h3, "R6 falling latched");
      // R8 clear
      wr(8'h14, 32'h1);
      rd(8'h10, 32'h2, "R8 clear one");
      wr(8'h14, 32'h0);
      rd(8'h10, 32'h2, "R8 zero no effect");
      wr(8'h14, 32'h2);
      rd(8'h10, 0, "R8 clear all");
      chk(32'(irq), 0, "R11 cleared");

      // R7 both-edge sensing
      wr(8'h4C, 32'h1);
      rd(8'h4C, 32'h1, "R7 readback");
      pins = 24'h3; tick(3);
      rd(8'h10, 32'h1, "R7 rising");
      wr(8'h14, 32'h1);
      pins = '0; tick(3);
      rd(8'h10, 32'h3, "R7 falling");
      wr(8'h14, 32'h3);
      rd(8'h10, 0, "R7 cleared");

      // R9 edge wins over clear in the same cycle
      pins = 24'h1; tick(3);
      pins = '0; tick(2);
      wr(8'h14, 32'h1);
      rd(8'h10, 32'h1, "R9 edge beats clear");
      wr(8'h14, 32'h1);
      rd(8'h10, 0, "R9 later clear");

      // R12 unmapped and write-only offsets
      rd(8'h30, 0, "R12 unmapped");
      rd(8'h14, 0, "R12 clear reads 0");
      rd(8'h1C, 0, "R12 unmask reads 0");

      tick(2);
      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule